// File: doc/BRIEF.md
# Relative-Addressed Register Stack Controller

This block keeps eight data registers arranged as a circular stack and decodes one command per cycle against it. Every register operand is named by its distance from a moving top pointer: logical entry ST(i) lives in physical slot (TOP + i) mod 8. Pushing moves the pointer down by one and popping moves it up by one. Each physical slot carries a valid tag, so the controller can tell an empty slot from a live one.

Commands cover pushing an external value, reading the top (with or without popping it), two-operand arithmetic between stack entries or between the top and an external operand, compares that pop zero, one or two entries, and a two-result operation that rewrites the top and then pushes a constant. The arithmetic is a plain two's-complement integer unit standing in for a floating-point datapath. A command that would push onto a live slot, or that reads or pops an empty slot, is refused. The stack is left as it was and an error pulse is raised instead.

All outputs are registered. The result of a command issued in cycle k appears after the clock edge that ends cycle k.

Top module: `rstack_ctrl`

## Requirements
- R1: After reset, top_ptr is 0, every slot is empty, ovf_flag, unf_flag, st_valid and the compare flags are 0, and a read of the top raises unf_flag.
- R2: Push (cmd_op=1) decrements top_ptr modulo 8 and writes cmd_data into the new ST(0). The previous top becomes ST(1).
- R3: A push or a two-result command whose target slot (the current ST(7)) is valid raises ovf_flag for one cycle and leaves top_ptr and all contents unchanged.
- R4: Store (cmd_op=2) places ST(0) on st_data with st_valid high for one cycle. With cmd_pop nonzero it also empties that slot and increments top_ptr.
- R5: Any command that reads or pops an empty slot raises unf_flag for one cycle and leaves the stack unchanged. Underflow wins over overflow when both apply.
- R6: Arithmetic (cmd_op=3) with cmd_dir=0, cmd_pop=0, cmd_mem=0 writes ST(0) fn ST(i) into ST(0).
- R7: Arithmetic with cmd_dir=1, cmd_pop=0, cmd_mem=0 writes ST(i) fn ST(0) into ST(i) and keeps top_ptr.
- R8: Arithmetic with cmd_pop nonzero and cmd_mem=0 writes ST(i) fn ST(0) into ST(i), then empties ST(0) and increments top_ptr.
- R9: Arithmetic with cmd_mem=1 computes ST(0) fn cmd_data into ST(0) and never pops, whatever cmd_pop holds.
- R10: cmd_rev=1 swaps the two arithmetic operands and keeps the destination. For example, a subtract with destination ST(i) gives ST(0)-ST(i), and a subtract with cmd_mem=1 gives cmd_data-ST(0).
- R11: Compare (cmd_op=4) compares ST(0) as signed against ST(i), or against cmd_data when cmd_mem=1. It sets exactly one of cmp_lt, cmp_eq, cmp_gt (ST(0) less, equal, greater) and holds it until the next compare. cmd_pop=0, 1 or 2 pops that many entries, and 2 also requires ST(1) valid.
- R12: The two-result command (cmd_op=5) replaces ST(0) with its negation and then pushes the constant 1, so top_ptr decrements.
- R13: cmd_fn selects the operation: 0 add, 1 subtract, 2 multiply (low 16 bits of the product). All results wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 none, 1 push, 2 store, 3 arithmetic, 4 compare, 5 two-result |
| cmd_fn | input | 2 | Arithmetic function: 0 add, 1 subtract, 2 multiply |
| cmd_idx | input | 3 | Relative stack index i |
| cmd_dir | input | 1 | 0: destination ST(0); 1: destination ST(i) |
| cmd_rev | input | 1 | Swap arithmetic operand order |
| cmd_pop | input | 2 | Pop count (store and arithmetic treat nonzero as one) |
| cmd_mem | input | 1 | Second operand taken from cmd_data |
| cmd_data | input | 16 | External operand or push value |
| st_data | output | 16 | Value read by the last store |
| st_valid | output | 1 | One-cycle pulse marking st_data |
| top_ptr | output | 3 | Current top pointer |
| ovf_flag | output | 1 | One-cycle overflow pulse |
| unf_flag | output | 1 | One-cycle underflow pulse |
| cmp_lt | output | 1 | Last compare: ST(0) less |
| cmp_eq | output | 1 | Last compare: equal |
| cmp_gt | output | 1 | Last compare: ST(0) greater |

## Verification
Arithmetic is driven with a non-commutative subtract on two distinct values in each of the forms: destination ST(0), destination ST(i), popping, external operand, and reversed. Each form therefore leaves a different value in a different slot, and a wrong operand order, destination or pop count shows up in the values popped afterwards. Pushes wrap the pointer through 0, and a full stack separates overflow from an ordinary push. Compares are run with less, equal and greater outcomes and with all three pop counts. Reads of empty slots, including a hole deep in the stack, show that refused commands change nothing.

// File: rtl/rstack_pkg.sv
// Shared encodings for the relative-addressed register stack.
// Assumes: command fields are decoded by rstack_decode only.
package rstack_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_ARITH = 3'd3,
        OP_CMP   = 3'd4,
        OP_DUAL  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_MUL = 2'd2
    } fn_e;

    typedef enum logic [1:0] {
        RS_ALU = 2'd0,
        RS_MEM = 2'd1,
        RS_NEG = 2'd2
    } rsel_e;
endpackage

// File: rtl/rstack_regs.sv
// Physical register array with a valid tag per slot.
// Two combinational read ports, two write ports that set the tag, and a
// clear mask that empties slots. Assumes the two writes never hit one slot;
// a clear wins over a write to the same slot.
module rstack_regs #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW-1:0]    rd_a_addr,
    input  logic [PW-1:0]    rd_b_addr,
    output logic [W-1:0]     rd_a_data,
    output logic [W-1:0]     rd_b_data,
    input  logic             wr0_en,
    input  logic [PW-1:0]    wr0_addr,
    input  logic [W-1:0]     wr0_data,
    input  logic             wr1_en,
    input  logic [PW-1:0]    wr1_addr,
    input  logic [W-1:0]     wr1_data,
    input  logic [DEPTH-1:0] clr_mask,
    output logic [DEPTH-1:0] tags
);
    logic [W-1:0] slot_w [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        logic [W-1:0] val_q;
        logic         tag_q;
        logic         hit0;
        logic         hit1;

        assign hit0 = wr0_en && (wr0_addr == PW'(e));
        assign hit1 = wr1_en && (wr1_addr == PW'(e));

        // Slot value: port 0 has priority over port 1.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= '0;
            else if (hit0)
                val_q <= wr0_data;
            else if (hit1)
                val_q <= wr1_data;
        end

        // Slot tag: cleared on pop, set on any write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tag_q <= 1'b0;
            else if (clr_mask[e])
                tag_q <= 1'b0;
            else if (hit0 || hit1)
                tag_q <= 1'b1;
        end

        assign slot_w[e] = val_q;
        assign tags[e]   = tag_q;
    end

    assign rd_a_data = slot_w[rd_a_addr];
    assign rd_b_data = slot_w[rd_b_addr];
endmodule

// File: rtl/rstack_alu.sv
// Integer stand-in for the arithmetic datapath.
// Applies the operand swap, computes add/sub/mul modulo 2^W, and a signed
// compare of x against y (always unswapped). Purely combinational.
module rstack_alu
    import rstack_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         rev,
    input  fn_e          fn,
    output logic [W-1:0] res,
    output logic         lt,
    output logic         eq,
    output logic         gt
);
    logic [W-1:0] opl;
    logic [W-1:0] opr;

    // Operand order for the non-commutative functions.
    always_comb begin
        opl = rev ? y : x;
        opr = rev ? x : y;
    end

    // Function select.
    always_comb begin
        unique case (fn)
            FN_ADD:  res = opl + opr;
            FN_SUB:  res = opl - opr;
            FN_MUL:  res = opl * opr;
            default: res = opl + opr;
        endcase
    end

    // Signed relation of x to y.
    always_comb begin
        lt = $signed(x) < $signed(y);
        eq = x == y;
        gt = $signed(x) > $signed(y);
    end
endmodule

// File: rtl/rstack_decode.sv
// Command decoder: turns one command and the current pointer and tags into
// physical read addresses, write enables, pop clears, the next pointer and
// the error pulses. Assumes DEPTH is a power of two so pointer sums wrap.
// A refused command produces no writes, no clears and no pointer motion.
module rstack_decode
    import rstack_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic             cmd_valid,
    input  op_e              op,
    input  logic [PW-1:0]    idx,
    input  logic             dir,
    input  logic             rev,
    input  logic [1:0]       pop,
    input  logic             mem,
    input  logic [PW-1:0]    top,
    input  logic [DEPTH-1:0] tags,
    output logic [PW-1:0]    ph_a,
    output logic [PW-1:0]    ph_b,
    output logic             b_mem,
    output logic             rev_eff,
    output logic             st_do,
    output logic             cmp_do,
    output logic             wr0_en,
    output logic [PW-1:0]    wr0_addr,
    output rsel_e            wr0_sel,
    output logic             wr1_en,
    output logic [PW-1:0]    wr1_addr,
    output logic [DEPTH-1:0] clr_mask,
    output logic [PW-1:0]    top_nxt,
    output logic             ovf,
    output logic             unf
);
    logic [PW-1:0]    p0, pi, p1, p2, pp;
    logic             sti;
    logic             ovf_r, unf_r, ok;
    logic             st_r, cmp_r, w0_r, w1_r;
    logic [DEPTH-1:0] clr_r;
    logic [PW-1:0]    tn_r;

    // Physical slots of the logical entries used by any command.
    always_comb begin
        p0 = top;
        pi = top + idx;
        p1 = top + PW'(1);
        p2 = top + PW'(2);
        pp = top - PW'(1);
    end

    // Per-command routing, stack motion and error detection.
    always_comb begin
        ph_a     = p0;
        ph_b     = pi;
        b_mem    = 1'b0;
        sti      = 1'b0;
        st_r     = 1'b0;
        cmp_r    = 1'b0;
        w0_r     = 1'b0;
        wr0_addr = p0;
        wr0_sel  = RS_ALU;
        w1_r     = 1'b0;
        wr1_addr = pp;
        clr_r    = '0;
        tn_r     = top;
        ovf_r    = 1'b0;
        unf_r    = 1'b0;
        unique case (op)
            OP_LOAD: begin
                ovf_r    = tags[pp];
                w0_r     = 1'b1;
                wr0_addr = pp;
                wr0_sel  = RS_MEM;
                tn_r     = pp;
            end
            OP_STORE: begin
                unf_r = !tags[p0];
                st_r  = 1'b1;
                if (pop != 2'd0) begin
                    clr_r[p0] = 1'b1;
                    tn_r      = p1;
                end
            end
            OP_ARITH: begin
                w0_r = 1'b1;
                if (mem) begin
                    b_mem    = 1'b1;
                    unf_r    = !tags[p0];
                    wr0_addr = p0;
                end else begin
                    sti      = dir || (pop != 2'd0);
                    ph_a     = sti ? pi : p0;
                    ph_b     = sti ? p0 : pi;
                    wr0_addr = sti ? pi : p0;
                    unf_r    = !tags[p0] || !tags[pi];
                    if (pop != 2'd0) begin
                        clr_r[p0] = 1'b1;
                        tn_r      = p1;
                    end
                end
            end
            OP_CMP: begin
                b_mem = mem;
                cmp_r = 1'b1;
                unf_r = !tags[p0] || (!mem && !tags[pi]);
                if (pop == 2'd1) begin
                    clr_r[p0] = 1'b1;
                    tn_r      = p1;
                end else if (pop >= 2'd2) begin
                    unf_r     = unf_r || !tags[p1];
                    clr_r[p0] = 1'b1;
                    clr_r[p1] = 1'b1;
                    tn_r      = p2;
                end
            end
            OP_DUAL: begin
                unf_r    = !tags[p0];
                ovf_r    = tags[pp];
                w0_r     = 1'b1;
                wr0_addr = p0;
                wr0_sel  = RS_NEG;
                w1_r     = 1'b1;
                wr1_addr = pp;
                tn_r     = pp;
            end
            default: begin
            end
        endcase
    end

    // Commit gating: an error or an idle cycle changes nothing.
    always_comb begin
        ok       = cmd_valid && !ovf_r && !unf_r;
        unf      = cmd_valid && unf_r;
        ovf      = cmd_valid && ovf_r && !unf_r;
        st_do    = ok && st_r;
        cmp_do   = ok && cmp_r;
        wr0_en   = ok && w0_r;
        wr1_en   = ok && w1_r;
        clr_mask = ok ? clr_r : '0;
        top_nxt  = ok ? tn_r : top;
        rev_eff  = rev && (op == OP_ARITH);
    end
endmodule

// File: rtl/rstack_ctrl.sv
// Top of the register stack controller. Holds the top pointer and the
// registered outputs, and wires decoder, register array and ALU together.
// Assumes at most one command per cycle; all outputs change on the clock
// edge that ends the command's cycle.
module rstack_ctrl
    import rstack_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [1:0]    cmd_fn,
    input  logic [PW-1:0] cmd_idx,
    input  logic          cmd_dir,
    input  logic          cmd_rev,
    input  logic [1:0]    cmd_pop,
    input  logic          cmd_mem,
    input  logic [W-1:0]  cmd_data,
    output logic [W-1:0]  st_data,
    output logic          st_valid,
    output logic [PW-1:0] top_ptr,
    output logic          ovf_flag,
    output logic          unf_flag,
    output logic          cmp_lt,
    output logic          cmp_eq,
    output logic          cmp_gt
);
    logic [PW-1:0]    top_q;
    logic [DEPTH-1:0] tags;
    logic [PW-1:0]    ph_a, ph_b, wr0_addr, wr1_addr, top_nxt;
    logic             b_mem, rev_eff, st_do, cmp_do, wr0_en, wr1_en, ovf, unf;
    rsel_e            wr0_sel;
    logic [DEPTH-1:0] clr_mask;
    logic [W-1:0]     rd_a, rd_b, opy, alu_res, wr0_data;
    logic             lt, eq, gt;

    rstack_decode #(.DEPTH(DEPTH)) u_dec (
        .cmd_valid (cmd_valid),
        .op        (op_e'(cmd_op)),
        .idx       (cmd_idx),
        .dir       (cmd_dir),
        .rev       (cmd_rev),
        .pop       (cmd_pop),
        .mem       (cmd_mem),
        .top       (top_q),
        .tags      (tags),
        .ph_a      (ph_a),
        .ph_b      (ph_b),
        .b_mem     (b_mem),
        .rev_eff   (rev_eff),
        .st_do     (st_do),
        .cmp_do    (cmp_do),
        .wr0_en    (wr0_en),
        .wr0_addr  (wr0_addr),
        .wr0_sel   (wr0_sel),
        .wr1_en    (wr1_en),
        .wr1_addr  (wr1_addr),
        .clr_mask  (clr_mask),
        .top_nxt   (top_nxt),
        .ovf       (ovf),
        .unf       (unf)
    );

    rstack_regs #(.DEPTH(DEPTH), .W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_addr (ph_a),
        .rd_b_addr (ph_b),
        .rd_a_data (rd_a),
        .rd_b_data (rd_b),
        .wr0_en    (wr0_en),
        .wr0_addr  (wr0_addr),
        .wr0_data  (wr0_data),
        .wr1_en    (wr1_en),
        .wr1_addr  (wr1_addr),
        .wr1_data  (W'(1)),
        .clr_mask  (clr_mask),
        .tags      (tags)
    );

    // Second operand: stack entry or external value.
    always_comb opy = b_mem ? cmd_data : rd_b;

    rstack_alu #(.W(W)) u_alu (
        .x   (rd_a),
        .y   (opy),
        .rev (rev_eff),
        .fn  (fn_e'(cmd_fn)),
        .res (alu_res),
        .lt  (lt),
        .eq  (eq),
        .gt  (gt)
    );

    // Source of the primary write port.
    always_comb begin
        unique case (wr0_sel)
            RS_MEM:  wr0_data = cmd_data;
            RS_NEG:  wr0_data = W'(0) - rd_a;
            default: wr0_data = alu_res;
        endcase
    end

    // Top pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_nxt;
    end

    // Store data and per-command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_data  <= '0;
            st_valid <= 1'b0;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            st_valid <= st_do;
            ovf_flag <= ovf;
            unf_flag <= unf;
            if (st_do) st_data <= rd_a;
        end
    end

    // Compare flags, held until the next accepted compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_lt <= 1'b0;
            cmp_eq <= 1'b0;
            cmp_gt <= 1'b0;
        end else if (cmp_do) begin
            cmp_lt <= lt;
            cmp_eq <= eq;
            cmp_gt <= gt;
        end
    end

    assign top_ptr = top_q;
endmodule

// File: rtl/rstack_ctrl_chk.sv
// Port-level checker for rstack_ctrl, attached by bind below.
// Assumes the opcode encodings of rstack_pkg.
module rstack_ctrl_chk #(
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic [1:0]    cmd_pop,
    input logic          cmd_mem,
    input logic          st_valid,
    input logic [PW-1:0] top_ptr,
    input logic          ovf_flag,
    input logic          unf_flag,
    input logic          cmp_lt,
    input logic          cmp_eq,
    input logic          cmp_gt
);
    // R2: an accepted push moves the pointer down by one.
    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1) |=>
            (ovf_flag || top_ptr == PW'($past(top_ptr) - PW'(1))));

    // R3 and R5: a refused command leaves the pointer where it was.
    p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag || unf_flag) |-> (top_ptr == $past(top_ptr)));

    // R5: underflow and overflow are never reported together.
    p_one_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_flag, unf_flag}));

    // R4: a popping store moves the pointer up by one.
    p_store_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2 && cmd_pop != 2'd0) |=>
            (unf_flag || top_ptr == PW'($past(top_ptr) + PW'(1))));

    // R4: store data is only marked valid after a store command.
    p_st_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> $past(cmd_valid && cmd_op == 3'd2));

    // R9: external-operand arithmetic never moves the pointer.
    p_mem_nopop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3 && cmd_mem) |=>
            (top_ptr == $past(top_ptr)));

    // R11: at most one compare outcome is held.
    p_cmp_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmp_lt, cmp_eq, cmp_gt}));
endmodule

bind rstack_ctrl rstack_ctrl_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_pop   (cmd_pop),
    .cmd_mem   (cmd_mem),
    .st_valid  (st_valid),
    .top_ptr   (top_ptr),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag),
    .cmp_lt    (cmp_lt),
    .cmp_eq    (cmp_eq),
    .cmp_gt    (cmp_gt)
);

// File: tb/rstack_ctrl_test.sv
// Directed bench for rstack_ctrl: one task per scenario, each checking its
// own results through the ports.
module rstack_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_fn = '0;
    logic [2:0]  cmd_idx = '0;
    logic        cmd_dir = 1'b0;
    logic        cmd_rev = 1'b0;
    logic [1:0]  cmd_pop = '0;
    logic        cmd_mem = 1'b0;
    logic [15:0] cmd_data = '0;
    logic [15:0] st_data;
    logic        st_valid;
    logic [2:0]  top_ptr;
    logic        ovf_flag, unf_flag, cmp_lt, cmp_eq, cmp_gt;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    rstack_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_fn(cmd_fn), .cmd_idx(cmd_idx), .cmd_dir(cmd_dir),
        .cmd_rev(cmd_rev), .cmd_pop(cmd_pop), .cmd_mem(cmd_mem),
        .cmd_data(cmd_data), .st_data(st_data), .st_valid(st_valid),
        .top_ptr(top_ptr), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
        .cmp_lt(cmp_lt), .cmp_eq(cmp_eq), .cmp_gt(cmp_gt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive one command for one cycle; outputs are valid on return.
    task automatic issue(input logic [2:0] op, input logic [1:0] fn,
                         input logic [2:0] idx, input logic dir, input logic rev,
                         input logic [1:0] pop, input logic mem, input logic [15:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_fn = fn; cmd_idx = idx;
        cmd_dir = dir; cmd_rev = rev; cmd_pop = pop; cmd_mem = mem; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic push(input logic [15:0] v);
        issue(3'd1, 2'd0, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, v);
    endtask

    task automatic pop_chk(input string tag, input logic [15:0] exp);
        issue(3'd2, 2'd0, 3'd0, 1'b0, 1'b0, 2'd1, 1'b0, 16'h0);
        chk({tag, " st_valid"}, st_valid, 1);
        chk({tag, " st_data"}, st_data, exp);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 top", top_ptr, 0);
        chk("R1 flags", {ovf_flag, unf_flag, st_valid, cmp_lt, cmp_eq, cmp_gt}, 0);
        issue(3'd2, 2'd0, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0);
        chk("R1 empty read unf", unf_flag, 1);
        chk("R1 no st_valid", st_valid, 0);
    endtask

    task automatic t_push_store();
        do_reset();
        push(16'd10); chk("R2 top after 1", top_ptr, 7);
        push(16'd20); push(16'd30); chk("R2 top after 3", top_ptr, 5);
        issue(3'd2, 2'd0, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0);
        chk("R4 store data", st_data, 30);
        chk("R4 no-pop top", top_ptr, 5);
        pop_chk("R4 pop 30", 16'd30); chk("R4 pop top", top_ptr, 6);
        pop_chk("R2 order 20", 16'd20);
        pop_chk("R2 order 10", 16'd10); chk("R4 top back", top_ptr, 0);
        issue(3'd2, 2'd0, 3'd0, 1'b0, 1'b0, 2'd1, 1'b0, 16'h0);
        chk("R5 emptied", unf_flag, 1);
        chk("R5 top kept", top_ptr, 0);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int k = 1; k <= 8; k++) push(16'(k));
        chk("R3 full top", top_ptr, 0);
        chk("R3 no ovf yet", ovf_flag, 0);
        push(16'd99);
        chk("R3 ovf", ovf_flag, 1);
        chk("R3 top kept", top_ptr, 0);
        pop_chk("R3 contents kept", 16'd8);
    endtask

    task automatic t_arith_st0();
        do_reset();
        push(16'd5); push(16'd3);
        issue(3'd3, 2'd1, 3'd1, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0);
        chk("R6 top", top_ptr, 6);
        pop_chk("R6 st0=3-5", 16'hFFFE);
        pop_chk("R6 st1 kept", 16'd5);
        push(16'd4); push(16'd6);
        issue(3'd3, 2'd0, 3'd1, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0);
        issue(3'd3, 2'd2, 3'd1, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0);
        pop_chk("R13 (6+4)*4", 16'd40);
    endtask

    task automatic t_arith_sti();
        do_reset();
        push(16'd5); push(16'd3);
        issue(3'd3, 2'd1, 3'd1, 1'b1, 1'b0, 2'd0, 1'b0, 16'h0);
        chk("R7 top", top_ptr, 6);
        pop_chk("R7 st0 kept", 16'd3);
        pop_chk("R7 st1=5-3", 16'd2);
    endtask

    task automatic t_pop_form();
        do_reset();
        push(16'd5); push(16'd3);
        issue(3'd3, 2'd1, 3'd1, 1'b0, 1'b0, 2'd1, 1'b0, 16'h0);
        chk("R8 top", top_ptr, 7);
        pop_chk("R8 new top=5-3", 16'd2);
        issue(3'd2, 2'd0, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0);
        chk("R8 one left", unf_flag, 1);
    endtask

    task automatic t_mem();
        do_reset();
        push(16'd7);
        issue(3'd3, 2'd0, 3'd0, 1'b0, 1'b0, 2'd1, 1'b1, 16'd100);
        chk("R9 no pop", top_ptr, 7);
        issue(3'd3, 2'd2, 3'd0, 1'b0, 1'b0, 2'd0, 1'b1, 16'd3);
        pop_chk("R9 R13 (7+100)*3", 16'd321);
    endtask

    task automatic t_reverse();
        do_reset();
        push(16'd5); push(16'd3);
        issue(3'd3, 2'd1, 3'd1, 1'b1, 1'b1, 2'd0, 1'b0, 16'h0);
        issue(3'd3, 2'd1, 3'd0, 1'b0, 1'b1, 2'd0, 1'b1, 16'd10);
        pop_chk("R10 mem-st0", 16'd7);
        pop_chk("R10 st0-sti", 16'hFFFE);
    endtask

    task automatic t_compare();
        do_reset();
        push(16'd5); push(16'd3);
        issue(3'd4, 2'd0, 3'd1, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0);
        chk("R11 lt", {cmp_lt, cmp_eq, cmp_gt}, 3'b100);
        chk("R11 pop0 top", top_ptr, 6);
        issue(3'd4, 2'd0, 3'd0, 1'b0, 1'b0, 2'd1, 1'b1, 16'd3);
        chk("R11 eq", {cmp_lt, cmp_eq, cmp_gt}, 3'b010);
        chk("R11 pop1 top", top_ptr, 7);
        push(16'd9);
        issue(3'd4, 2'd0, 3'd1, 1'b0, 1'b0, 2'd2, 1'b0, 16'h0);
        chk("R11 gt", {cmp_lt, cmp_eq, cmp_gt}, 3'b001);
        chk("R11 pop2 top", top_ptr, 0);
        issue(3'd2, 2'd0, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0);
        chk("R11 both popped", unf_flag, 1);
        chk("R11 flags held", {cmp_lt, cmp_eq, cmp_gt}, 3'b001);
    endtask

    task automatic t_underflow();
        do_reset();
        push(16'd4);
        issue(3'd3, 2'd0, 3'd3, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0);
        chk("R5 arith unf", unf_flag, 1);
        chk("R5 top kept", top_ptr, 7);
        issue(3'd4, 2'd0, 3'd1, 1'b0, 1'b0, 2'd2, 1'b0, 16'h0);
        chk("R5 cmp unf", unf_flag, 1);
        pop_chk("R5 value kept", 16'd4);
    endtask

    task automatic t_dual();
        do_reset();
        push(16'd6);
        issue(3'd5, 2'd0, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0);
        chk("R12 top", top_ptr, 6);
        pop_chk("R12 const one", 16'd1);
        pop_chk("R12 negated", 16'hFFFA);
        for (int k = 1; k <= 8; k++) push(16'(k));
        issue(3'd5, 2'd0, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0);
        chk("R12 R3 ovf", ovf_flag, 1);
        pop_chk("R12 top kept", 16'd8);
    endtask

    initial begin
        t_reset();
        t_push_store();
        t_overflow();
        t_arith_st0();
        t_arith_sti();
        t_pop_form();
        t_mem();
        t_reverse();
        t_compare();
        t_underflow();
        t_dual();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule